// File: doc/BRIEF.md
# Difference-of-Means Power Trace Accumulator

This block gathers power acquisitions for a difference-of-means analysis of the last round of AES-128. Each acquisition is one ciphertext byte followed by a fixed number of signed power samples. When the byte arrives, the block applies the inverse byte substitution to the byte XOR the current key-byte guess and picks one bit of the result. That bit sends every sample of the acquisition into group 0 or group 1. Each group has one signed running sum per sample position and a count of the acquisitions it holds. Plaintext is never needed.

On a finish command the block divides each running sum by its group count, one after another, using a shared sequential restoring divider. It streams out the difference of the two means, group 1 minus group 0, at each sample position. While streaming it keeps the largest absolute difference and the position where it occurred, and reports both with a done pulse. A host sweeps the 256 guesses for each of the 16 key bytes. Between guesses it clears the block and replays the same stored acquisitions. A guess whose difference trace shows a clear peak is the likely key byte.

Top module: `dpa_diff_mean`

## Requirements
- R1: The group bit of an acquisition is bit `bitsel_i` (0 = LSB) of InvS(`ct_byte_i` XOR `guess_i`). InvS is the inverse affine map followed by the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapping to 0. Examples: InvS(0x63)=0x00 and InvS(0x00)=0x52. Guess and bit index are taken in the cycle the ciphertext byte is accepted.
- R2: While idle, the block accepts a ciphertext byte on a cycle with `ct_valid_i` high. After that, each cycle with `smp_valid_i` high delivers the next sample, positions 0 to NSAMP-1 in order. Sample j is added to the group's running sum at position j. The group count rises by one when the last sample is accepted. A sample offered while idle is ignored.
- R3: Output sample j is trunc(sum1[j]/count1) minus trunc(sum0[j]/count0). Each quotient is rounded toward zero, and the difference is clamped to the signed 16-bit range.
- R4: A finish command accepted while idle produces NSAMP single-cycle `out_valid_o` pulses with `out_idx_o` running 0 to NSAMP-1 in order. These are followed by one single-cycle `done_o` pulse that never coincides with `out_valid_o`.
- R5: At `done_o`, `peak_mag_o` is the largest |out_diff_o| of that pass and `peak_idx_o` is the lowest position where it occurs. With no nonzero point, both are 0.
- R6: If either group count is zero at finish, every output sample is 0, both peak values are 0, and `invalid_o` is high. `invalid_o` keeps the value it took at the last accepted finish.
- R7: `clear_i`, accepted while idle or in the middle of an acquisition, zeroes both groups' sums and counts and discards the partial acquisition. It has priority over a ciphertext byte or finish in the same cycle.
- R8: During an output pass, `clear_i`, `finish_i`, `ct_valid_i` and `smp_valid_i` are ignored. A finish does not alter the sums or counts, so a later finish repeats the same trace and more acquisitions can be added on top.
- R9: After reset, `out_valid_o`, `done_o`, `invalid_o`, `peak_mag_o` and `out_diff_o` are 0 and both groups are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| guess_i | input | 8 | Key-byte guess |
| bitsel_i | input | 3 | Index of the selection bit |
| clear_i | input | 1 | Zero all sums and counts |
| ct_valid_i | input | 1 | Ciphertext byte present |
| ct_byte_i | input | 8 | Ciphertext byte |
| smp_valid_i | input | 1 | Power sample present |
| smp_i | input | 12 | Signed power sample |
| finish_i | input | 1 | Start an output pass |
| out_valid_o | output | 1 | Output sample strobe |
| out_idx_o | output | $clog2(NSAMP) | Position of the output sample |
| out_diff_o | output | 16 | Signed difference of means |
| done_o | output | 1 | End of output pass |
| invalid_o | output | 1 | A group was empty at finish |
| peak_mag_o | output | 16 | Largest absolute difference |
| peak_idx_o | output | $clog2(NSAMP) | Position of the largest difference |

## Verification
A wrong group bit, a sample added at the wrong position, or a miscounted acquisition shows up only at the next output pass. The difference trace moves at the affected positions, by the sample's weight divided by the group count, and the peak may move with it. A fault in the divider or its sign handling is visible at every position of the first pass. The directed rounding cases show a floor-versus-truncate slip as an error of one at position 0. An input that is wrongly taken during the output pass shows up when a repeated finish no longer reproduces the trace.

// File: rtl/dpa_pkg.sv
// Shared types and field arithmetic for the difference-of-means accumulator.
// Assumes byte-wide GF(2^8) elements reduced by x^8+x^4+x^3+x+1.
package dpa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMP,
        ST_LOAD,
        ST_WAIT1,
        ST_WAIT0,
        ST_FIN
    } dpa_state_e;

    // Shift-and-add field multiply with reduction on each shift.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254; zero maps to zero.
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] res;
        logic [7:0] sq;
        res = 8'h01;
        sq  = a;
        for (int i = 1; i < 8; i++) begin
            sq  = gf_mul(sq, sq);
            res = gf_mul(res, sq);
        end
        return res;
    endfunction

    // Inverse of the substitution's affine step.
    function automatic logic [7:0] inv_affine(input logic [7:0] b);
        logic [7:0] y;
        for (int i = 0; i < 8; i++) begin
            y[i] = b[(i + 2) % 8] ^ b[(i + 5) % 8] ^ b[(i + 7) % 8];
        end
        return y ^ 8'h05;
    endfunction

endpackage

// File: rtl/dpa_inv_sbox.sv
// Combinational inverse byte substitution.
// Assumes the caller registers the result; no pipeline stage inside.
module dpa_inv_sbox
    import dpa_pkg::*;
(
    input  logic [7:0] din_i,
    output logic [7:0] dout_o
);

    // Undo the affine map, then take the field inverse.
    always_comb begin
        dout_o = gf_inv(inv_affine(din_i));
    end

endmodule

// File: rtl/dpa_acc_bank.sv
// One group of per-position signed running sums plus an acquisition count.
// Assumes at most one add per cycle; sums and count wrap on overflow.
module dpa_acc_bank #(
    parameter int NSAMP = 16,
    parameter int SW    = 12,
    parameter int AW    = 32,
    parameter int CW    = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_i,
    input  logic                         add_i,
    input  logic                         inc_i,
    input  logic [$clog2(NSAMP)-1:0]     idx_i,
    input  logic signed [SW-1:0]         val_i,
    input  logic [$clog2(NSAMP)-1:0]     rd_idx_i,
    output logic signed [AW-1:0]         rd_acc_o,
    output logic [CW-1:0]                cnt_o
);

    logic signed [AW-1:0] acc_q [NSAMP];
    logic signed [AW-1:0] val_ext;

    // Sign-extend the incoming sample to sum width.
    assign val_ext = {{(AW - SW){val_i[SW-1]}}, val_i};

    // Asynchronous read port used by the output pass.
    assign rd_acc_o = acc_q[rd_idx_i];

    // Sum and count update with clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            for (int j = 0; j < NSAMP; j++) acc_q[j] <= '0;
            cnt_o <= '0;
        end else begin
            if (add_i) acc_q[idx_i] <= acc_q[idx_i] + val_ext;
            if (inc_i) cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/dpa_udiv.sv
// Sequential restoring divider: one quotient bit per cycle, MSB first.
// Assumes a nonzero divisor; done pulses NW cycles after start.
module dpa_udiv #(
    parameter int NW = 32,
    parameter int DW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic          done_o,
    output logic [NW-1:0] quo_o
);

    localparam int CTW = $clog2(NW);
    localparam logic [CTW-1:0] LAST_STEP = CTW'(NW - 1);

    logic [DW-1:0]  rem_q;
    logic [DW-1:0]  den_q;
    logic [NW-1:0]  sh_q;
    logic [CTW-1:0] step_q;
    logic           busy_q;
    logic [DW:0]    trial;
    logic [DW:0]    trial_sub;
    logic           fits;
    logic [DW-1:0]  rem_nx;

    // Trial subtraction of the divisor from the shifted remainder.
    always_comb begin
        trial     = {rem_q, sh_q[NW-1]};
        trial_sub = trial - {1'b0, den_q};
        fits      = (trial >= {1'b0, den_q});
        rem_nx    = fits ? trial_sub[DW-1:0] : trial[DW-1:0];
    end

    assign quo_o = sh_q;

    // Iteration control and quotient shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= '0;
            sh_q   <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                rem_q  <= '0;
                den_q  <= den_i;
                sh_q   <= num_i;
                step_q <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= rem_nx;
                sh_q   <= {sh_q[NW-2:0], fits};
                step_q <= step_q + 1'b1;
                if (step_q == LAST_STEP) begin
                    busy_q <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dpa_diff_mean.sv
// Difference-of-means accumulator: routes each acquisition into one of two
// groups by an inverse-substitution bit, then streams mean1 - mean0 per position.
// Assumes NSAMP >= 2, SW < AW, OW <= 31 and that the host respects idle-only commands.
module dpa_diff_mean
    import dpa_pkg::*;
#(
    parameter int NSAMP = 16,
    parameter int SW    = 12,
    parameter int AW    = 32,
    parameter int CW    = 20,
    parameter int OW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               guess_i,
    input  logic [2:0]               bitsel_i,
    input  logic                     clear_i,
    input  logic                     ct_valid_i,
    input  logic [7:0]               ct_byte_i,
    input  logic                     smp_valid_i,
    input  logic signed [SW-1:0]     smp_i,
    input  logic                     finish_i,
    output logic                     out_valid_o,
    output logic [$clog2(NSAMP)-1:0] out_idx_o,
    output logic signed [OW-1:0]     out_diff_o,
    output logic                     done_o,
    output logic                     invalid_o,
    output logic [OW-1:0]            peak_mag_o,
    output logic [$clog2(NSAMP)-1:0] peak_idx_o
);

    localparam int IW = $clog2(NSAMP);
    localparam logic [IW-1:0] LAST = IW'(NSAMP - 1);
    localparam logic signed [AW+1:0] SAT_HI = (AW + 2)'(2 ** (OW - 1) - 1);
    localparam logic signed [AW+1:0] SAT_LO = ~SAT_HI;

    dpa_state_e           st_q;
    logic [IW-1:0]        sidx_q;
    logic [IW-1:0]        pt_q;
    logic                 sel_q;
    logic                 neg_q;
    logic [7:0]           sbox_out;
    logic                 sel_now;
    logic                 accept_ct;
    logic                 accept_smp;
    logic                 accept_fin;
    logic                 bank_clr;
    logic [1:0]           add_en;
    logic [1:0]           inc_en;
    logic signed [AW-1:0] rd_acc [2];
    logic [CW-1:0]        cnt [2];
    logic                 grp;
    logic signed [AW-1:0] div_src;
    logic                 src_neg;
    logic [AW-1:0]        div_num;
    logic                 div_start;
    logic                 div_done;
    logic [AW-1:0]        div_quo;
    logic signed [AW:0]   q_signed;
    logic signed [AW:0]   m1_q;
    logic signed [AW+1:0] diff_w;
    logic signed [OW-1:0] diff_sat;
    logic                 emit_now;
    logic signed [OW-1:0] emit_val;
    logic [OW-1:0]        emit_mag;

    dpa_inv_sbox i_sbox (
        .din_i  (ct_byte_i ^ guess_i),
        .dout_o (sbox_out)
    );

    // Command decode: clear beats a ciphertext byte, which beats finish.
    always_comb begin
        sel_now    = sbox_out[bitsel_i];
        bank_clr   = clear_i && (st_q == ST_IDLE || st_q == ST_SAMP);
        accept_ct  = (st_q == ST_IDLE) && !clear_i && ct_valid_i;
        accept_fin = (st_q == ST_IDLE) && !clear_i && !ct_valid_i && finish_i;
        accept_smp = (st_q == ST_SAMP) && !clear_i && smp_valid_i;
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        assign add_en[g] = accept_smp && (sel_q == 1'(g));
        assign inc_en[g] = add_en[g] && (sidx_q == LAST);

        dpa_acc_bank #(
            .NSAMP (NSAMP),
            .SW    (SW),
            .AW    (AW),
            .CW    (CW)
        ) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (bank_clr),
            .add_i    (add_en[g]),
            .inc_i    (inc_en[g]),
            .idx_i    (sidx_q),
            .val_i    (smp_i),
            .rd_idx_i (pt_q),
            .rd_acc_o (rd_acc[g]),
            .cnt_o    (cnt[g])
        );
    end

    // Divider operand select: group 1 first, then group 0.
    always_comb begin
        grp       = (st_q == ST_LOAD);
        div_src   = rd_acc[grp];
        src_neg   = div_src[AW-1];
        div_num   = src_neg ? (~div_src + 1'b1) : div_src;
        div_start = ((st_q == ST_LOAD) && !invalid_o) || ((st_q == ST_WAIT1) && div_done);
    end

    dpa_udiv #(
        .NW (AW),
        .DW (CW)
    ) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (cnt[grp]),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    // Restore the sign, subtract the means and clamp to the output width.
    always_comb begin
        q_signed = neg_q ? -$signed({1'b0, div_quo}) : $signed({1'b0, div_quo});
        diff_w   = {m1_q[AW], m1_q} - {q_signed[AW], q_signed};
        if (diff_w > SAT_HI)      diff_sat = OW'(SAT_HI);
        else if (diff_w < SAT_LO) diff_sat = OW'(SAT_LO);
        else                      diff_sat = OW'(diff_w);
        emit_now = ((st_q == ST_LOAD) && invalid_o) || ((st_q == ST_WAIT0) && div_done);
        emit_val = invalid_o ? '0 : diff_sat;
        emit_mag = emit_val[OW-1] ? (~emit_val + 1'b1) : emit_val;
    end

    // Main sequencer: acquisition, output pass and peak tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            sidx_q      <= '0;
            pt_q        <= '0;
            sel_q       <= 1'b0;
            neg_q       <= 1'b0;
            m1_q        <= '0;
            out_valid_o <= 1'b0;
            out_idx_o   <= '0;
            out_diff_o  <= '0;
            done_o      <= 1'b0;
            invalid_o   <= 1'b0;
            peak_mag_o  <= '0;
            peak_idx_o  <= '0;
        end else begin
            out_valid_o <= 1'b0;
            done_o      <= 1'b0;
            if (div_start) neg_q <= src_neg;
            case (st_q)
                ST_IDLE: begin
                    if (accept_ct) begin
                        sel_q  <= sel_now;
                        sidx_q <= '0;
                        st_q   <= ST_SAMP;
                    end else if (accept_fin) begin
                        invalid_o  <= (cnt[0] == '0) || (cnt[1] == '0);
                        pt_q       <= '0;
                        peak_mag_o <= '0;
                        peak_idx_o <= '0;
                        st_q       <= ST_LOAD;
                    end
                end
                ST_SAMP: begin
                    if (clear_i) begin
                        st_q <= ST_IDLE;
                    end else if (accept_smp) begin
                        if (sidx_q == LAST) st_q <= ST_IDLE;
                        else                sidx_q <= sidx_q + 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (!invalid_o) st_q <= ST_WAIT1;
                end
                ST_WAIT1: begin
                    if (div_done) begin
                        m1_q <= q_signed;
                        st_q <= ST_WAIT0;
                    end
                end
                ST_WAIT0: ;
                ST_FIN: begin
                    done_o <= 1'b1;
                    st_q   <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
            if (emit_now) begin
                out_valid_o <= 1'b1;
                out_idx_o   <= pt_q;
                out_diff_o  <= emit_val;
                if (emit_mag > peak_mag_o) begin
                    peak_mag_o <= emit_mag;
                    peak_idx_o <= pt_q;
                end
                if (pt_q == LAST) begin
                    st_q <= ST_FIN;
                end else begin
                    pt_q <= pt_q + 1'b1;
                    st_q <= ST_LOAD;
                end
            end
        end
    end

endmodule

// File: rtl/dpa_diff_mean_chk.sv
// Port-level checker for the output pass of dpa_diff_mean.
// Assumes it is bound to the top and sees only its outputs.
module dpa_diff_mean_chk #(
    parameter int NSAMP = 16,
    parameter int OW    = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     out_valid_o,
    input logic [$clog2(NSAMP)-1:0] out_idx_o,
    input logic signed [OW-1:0]     out_diff_o,
    input logic                     done_o,
    input logic                     invalid_o,
    input logic [OW-1:0]            peak_mag_o,
    input logic [$clog2(NSAMP)-1:0] peak_idx_o
);

    localparam int IW = $clog2(NSAMP);

    logic [IW:0]   seen_q;
    logic [OW-1:0] run_max_q;
    logic [IW-1:0] run_idx_q;
    logic [OW-1:0] cur_mag;

    assign cur_mag = out_diff_o[OW-1] ? (~out_diff_o + 1'b1) : out_diff_o;

    // Independent tally of emitted points and their running maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || done_o) begin
            seen_q    <= '0;
            run_max_q <= '0;
            run_idx_q <= '0;
        end else if (out_valid_o) begin
            seen_q <= seen_q + 1'b1;
            if (cur_mag > run_max_q) begin
                run_max_q <= cur_mag;
                run_idx_q <= out_idx_o;
            end
        end
    end

    // R4: points leave in position order.
    p_idx_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (seen_q < (IW + 1)'(NSAMP)) && (out_idx_o == seen_q[IW-1:0]));

    // R4: done follows exactly NSAMP points.
    p_count_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (seen_q == (IW + 1)'(NSAMP)));

    // R4: done is a single-cycle pulse.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: done never coincides with a point.
    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid_o && done_o));

    // R6: an invalid pass emits only zeros.
    p_invalid_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && invalid_o) |-> (out_diff_o == '0));

    // R5: reported peak equals the largest emitted magnitude, first position.
    p_peak_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (peak_mag_o == run_max_q) && (peak_idx_o == run_idx_q));

endmodule

bind dpa_diff_mean dpa_diff_mean_chk #(
    .NSAMP (NSAMP),
    .OW    (OW)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid_o (out_valid_o),
    .out_idx_o   (out_idx_o),
    .out_diff_o  (out_diff_o),
    .done_o      (done_o),
    .invalid_o   (invalid_o),
    .peak_mag_o  (peak_mag_o),
    .peak_idx_o  (peak_idx_o)
);

// File: tb/test_dpa_diff_mean.sv
// Self-checking bench for dpa_diff_mean: directed corners plus seeded random acquisitions.
module test_dpa_diff_mean;

    localparam int NSAMP = 16;
    localparam int IW    = $clog2(NSAMP);
    localparam int MAXT  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        guess_i = 8'h00;
    logic [2:0]        bitsel_i = 3'd0;
    logic              clear_i = 1'b0;
    logic              ct_valid_i = 1'b0;
    logic [7:0]        ct_byte_i = 8'h00;
    logic              smp_valid_i = 1'b0;
    logic signed [11:0] smp_i = '0;
    logic              finish_i = 1'b0;
    logic              out_valid_o;
    logic [IW-1:0]     out_idx_o;
    logic signed [15:0] out_diff_o;
    logic              done_o;
    logic              invalid_o;
    logic [15:0]       peak_mag_o;
    logic [IW-1:0]     peak_idx_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    logic [7:0]          inv_tab [256];
    logic [7:0]          tc [MAXT];
    logic signed [11:0]  ts [MAXT][NSAMP];
    longint              m_sum [2][NSAMP];
    longint              m_cnt [2];
    int                  got_d [NSAMP];
    int                  prev_d [NSAMP];
    int                  got_n;
    int                  got_pm;
    int                  got_pi;
    int                  got_inv;

    dpa_diff_mean i_dpa_diff_mean (
        .clk         (clk),
        .rst_n       (rst_n),
        .guess_i     (guess_i),
        .bitsel_i    (bitsel_i),
        .clear_i     (clear_i),
        .ct_valid_i  (ct_valid_i),
        .ct_byte_i   (ct_byte_i),
        .smp_valid_i (smp_valid_i),
        .smp_i       (smp_i),
        .finish_i    (finish_i),
        .out_valid_o (out_valid_o),
        .out_idx_o   (out_idx_o),
        .out_diff_o  (out_diff_o),
        .done_o      (done_o),
        .invalid_o   (invalid_o),
        .peak_mag_o  (peak_mag_o),
        .peak_idx_o  (peak_idx_o)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run is one failed check and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk = n_chk + 1;
            n_err = n_err + 1;
            $display("FAIL R4 watchdog: got %0d cycles expected at most 150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = 16'h0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
        return (x << n) | (x >> (8 - n));
    endfunction

    // Inverse table built by inverting the forward substitution.
    task automatic build_tab();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] iv;
            logic [7:0] s;
            iv = 8'h00;
            for (int y = 1; y < 256; y++) if (b_mul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
            s = iv ^ rotl8(iv, 1) ^ rotl8(iv, 2) ^ rotl8(iv, 3) ^ rotl8(iv, 4) ^ 8'h63;
            inv_tab[s] = 8'(x);
        end
    endtask

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_err = n_err + 1;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_diff(input int j);
        longint a;
        longint b;
        longint d;
        if (m_cnt[0] == 0 || m_cnt[1] == 0) return 0;
        a = m_sum[1][j] / m_cnt[1];
        b = m_sum[0][j] / m_cnt[0];
        d = a - b;
        if (d > 32767) d = 32767;
        if (d < -32768) d = -32768;
        return int'(d);
    endfunction

    task automatic model_clear();
        for (int g = 0; g < 2; g++) begin
            m_cnt[g] = 0;
            for (int j = 0; j < NSAMP; j++) m_sum[g][j] = 0;
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        model_clear();
    endtask

    // Send stored acquisition t, optionally with idle gaps between samples.
    task automatic send_trace(input int t, input bit gaps);
        int g;
        g = int'(inv_tab[tc[t] ^ guess_i][bitsel_i]);
        @(negedge clk);
        ct_valid_i = 1'b1;
        ct_byte_i  = tc[t];
        @(negedge clk);
        ct_valid_i = 1'b0;
        for (int j = 0; j < NSAMP; j++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                smp_valid_i = 1'b0;
                smp_i = 12'sh7FF;
                @(negedge clk);
            end
            smp_valid_i = 1'b1;
            smp_i = ts[t][j];
            @(negedge clk);
        end
        smp_valid_i = 1'b0;
        m_cnt[g] = m_cnt[g] + 1;
        for (int j = 0; j < NSAMP; j++) m_sum[g][j] = m_sum[g][j] + longint'(ts[t][j]);
    endtask

    // Pulse finish and gather one full output pass.
    task automatic run_finish();
        got_n = 0;
        for (int j = 0; j < NSAMP; j++) got_d[j] = 99999;
        @(negedge clk);
        finish_i = 1'b1;
        @(negedge clk);
        finish_i = 1'b0;
        while (!done_o) begin
            if (out_valid_o) begin
                got_d[out_idx_o] = int'(out_diff_o);
                got_n = got_n + 1;
            end
            @(negedge clk);
        end
        got_pm  = int'(peak_mag_o);
        got_pi  = int'(peak_idx_o);
        got_inv = int'(invalid_o);
    endtask

    // Compare a gathered pass with the bench model.
    task automatic verify(input string tag);
        int pm;
        int pi;
        pm = 0;
        pi = 0;
        chk({tag, " R4 point count"}, got_n, NSAMP);
        for (int j = 0; j < NSAMP; j++) begin
            int e;
            int m;
            e = exp_diff(j);
            chk({tag, " R3 diff"}, got_d[j], e);
            m = (e < 0) ? -e : e;
            if (m > pm) begin
                pm = m;
                pi = j;
            end
        end
        chk({tag, " R5 peak mag"}, got_pm, pm);
        chk({tag, " R5 peak idx"}, got_pi, pi);
        chk({tag, " R6 invalid"}, got_inv, (m_cnt[0] == 0 || m_cnt[1] == 0) ? 1 : 0);
    endtask

    function automatic int find_ct(input logic [7:0] g, input int b, input int want, input int skip);
        int hits;
        hits = 0;
        for (int c = 0; c < 256; c++) begin
            if (int'(inv_tab[8'(c) ^ g][b]) == want) begin
                if (hits == skip) return c;
                hits = hits + 1;
            end
        end
        return 0;
    endfunction

    task automatic fill_const(input int t, input logic [7:0] c, input int v);
        tc[t] = c;
        for (int j = 0; j < NSAMP; j++) ts[t][j] = 12'(v);
    endtask

    task automatic fill_rand(input int t);
        tc[t] = 8'($urandom);
        for (int j = 0; j < NSAMP; j++) ts[t][j] = 12'($urandom);
    endtask

    initial begin
        void'($urandom(32'd4242));
        build_tab();
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state.
        chk("R9 out_valid", out_valid_o, 0);
        chk("R9 done", done_o, 0);
        chk("R9 invalid", invalid_o, 0);
        chk("R9 peak", peak_mag_o, 0);
        chk("R9 diff", out_diff_o, 0);
        run_finish();
        chk("R9 empty groups give invalid (R6)", got_inv, 1);

        // R1: InvS(0x63)=0x00 -> bit1=0 group 0; InvS(0x00)=0x52 -> bit1=1 group 1.
        guess_i = 8'h5A;
        bitsel_i = 3'd1;
        do_clear();
        fill_const(0, 8'h63 ^ 8'h5A, 100);
        fill_const(1, 8'h00 ^ 8'h5A, 40);
        send_trace(0, 1'b0);
        send_trace(1, 1'b0);
        run_finish();
        chk("R1 selection from inverse substitution", got_d[0], -60);
        chk("R1 selection last position", got_d[NSAMP-1], -60);
        verify("R1");

        // R3: truncation toward zero: sums +3/2 and -3/2 give 1 - (-1) = 2.
        guess_i = 8'h00;
        bitsel_i = 3'd0;
        do_clear();
        fill_const(2, 8'(find_ct(8'h00, 0, 1, 0)), 1);
        fill_const(3, 8'(find_ct(8'h00, 0, 1, 1)), 2);
        fill_const(4, 8'(find_ct(8'h00, 0, 0, 0)), -1);
        fill_const(5, 8'(find_ct(8'h00, 0, 0, 1)), -2);
        ts[3][5] = 12'sd7;
        for (int t = 2; t < 6; t++) send_trace(t, 1'b1);
        run_finish();
        chk("R3 truncate toward zero", got_d[0], 2);
        verify("R3 trunc");

        // R6: only group 0 populated.
        bitsel_i = 3'd2;
        do_clear();
        for (int t = 6; t < 9; t++) fill_const(t, 8'(find_ct(8'h00, 2, 0, t)), t * 11);
        for (int t = 6; t < 9; t++) send_trace(t, 1'b0);
        run_finish();
        chk("R6 invalid flag", got_inv, 1);
        chk("R6 zero output", got_d[3], 0);
        chk("R6 zero peak", got_pm, 0);
        verify("R6");

        // R8: add one group 1 trace on top of the earlier ones, no clear.
        fill_const(9, 8'(find_ct(8'h00, 2, 1, 0)), -500);
        ts[9][7] = -12'sd2048;
        send_trace(9, 1'b0);
        run_finish();
        chk("R8 accumulation continues after finish", got_inv, 0);
        verify("R8 continue");

        // R5: extremes, tie on every position resolves to the lowest index.
        bitsel_i = 3'd3;
        do_clear();
        fill_const(10, 8'(find_ct(8'h00, 3, 1, 0)), 2047);
        fill_const(11, 8'(find_ct(8'h00, 3, 0, 0)), -2048);
        send_trace(10, 1'b0);
        send_trace(11, 1'b0);
        run_finish();
        chk("R5 extreme diff", got_d[9], 4095);
        chk("R5 tie lowest index", got_pi, 0);
        verify("R5");

        // R7: clear in mid-acquisition discards the partial trace.
        guess_i = 8'hC3;
        bitsel_i = 3'd6;
        do_clear();
        for (int t = 12; t < 20; t++) fill_rand(t);
        send_trace(12, 1'b0);
        @(negedge clk);
        ct_valid_i = 1'b1;
        ct_byte_i  = tc[13];
        @(negedge clk);
        ct_valid_i = 1'b0;
        for (int j = 0; j < 5; j++) begin
            smp_valid_i = 1'b1;
            smp_i = 12'sd1500;
            @(negedge clk);
        end
        smp_valid_i = 1'b0;
        do_clear();
        // R2: samples offered while idle are ignored.
        for (int j = 0; j < 4; j++) begin
            smp_valid_i = 1'b1;
            smp_i = 12'sd900;
            @(negedge clk);
        end
        smp_valid_i = 1'b0;
        for (int t = 14; t < 20; t++) send_trace(t, 1'b1);
        run_finish();
        verify("R7 R2");

        // R2: random acquisitions, replayed under several guesses and bits.
        for (int t = 20; t < 60; t++) fill_rand(t);
        for (int r = 0; r < 4; r++) begin
            guess_i  = 8'($urandom);
            bitsel_i = 3'($urandom);
            do_clear();
            for (int t = 20; t < 60; t++) send_trace(t, 1'b1);
            run_finish();
            verify("R2 random");
        end

        // R8: inputs during the output pass are ignored; a repeat finish matches.
        for (int j = 0; j < NSAMP; j++) prev_d[j] = got_d[j];
        fork
            run_finish();
            begin
                repeat (3) @(negedge clk);
                for (int k = 0; k < 300; k++) begin
                    clear_i     = ($urandom % 8 == 0);
                    ct_valid_i  = ($urandom % 3 == 0);
                    ct_byte_i   = 8'($urandom);
                    smp_valid_i = ($urandom % 2 == 0);
                    smp_i       = 12'($urandom);
                    @(negedge clk);
                end
                clear_i = 1'b0;
                ct_valid_i = 1'b0;
                smp_valid_i = 1'b0;
            end
        join
        for (int j = 0; j < NSAMP; j++) chk("R8 ignored during output", got_d[j], prev_d[j]);
        run_finish();
        verify("R8 repeat");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule